// File: doc/BRIEF.md
# IF Synthesiser Counter Core with Dual-Modulus Control and Lock Gating

This block holds the digital counters of an intermediate-frequency synthesiser. A feedback path divides the oscillator-side tick stream by M·N+A. It does this with a prescaler model that switches between N and N+1, plus a frame counter that keeps the prescaler on N+1 for the first A prescaler cycles of every M-cycle frame. A second counter divides the reference tick stream by a programmable 15-bit value R. The prescaler base N is chosen by a 3-bit code.

A phase/frequency comparator turns the two divided pulses into pump-up and pump-down controls. Its sense can be swapped and its outputs can be parked in an inactive state. The comparator also watches its own pulse activity and declares local lock after a run of quiet reference periods. The lock flag has a selectable polarity. It can be replaced by the companion synthesiser's lock, and it is then ANDed with an external lock input. A programming that cannot produce M·N+A is flagged and not applied; the last valid setting stays in force.

Both clocks arrive as tick enables (`vco_en_i`, `ref_en_i`) sampled in the single core clock `clk`.

Top module: `pll_if_synth_div`

## Requirements
- R1: With `vco_en_i` high every cycle, `fdiv_o` is a one-cycle pulse whose period is exactly M·N+A clock cycles.
- R2: The prescaler base N follows `psc_code_i`: any code with bit 2 at 0 gives 8, 3'b100 gives 16, 3'b101 gives 32, 3'b110 gives 64, and 3'b111 gives 128.
- R3: `mod_ctl_o` is high (modulus N+1) for the first A prescaler cycles of each frame and low for the rest. With `vco_en_i` high every cycle, it is high for A·(N+1) cycles per `fdiv_o` period.
- R4: A programming is invalid when A ≥ N, M < A, M = 0 or R = 0. `prog_err_o` rises one cycle after invalid inputs appear, and both dividers keep running with the last valid setting.
- R5: `rdiv_o` pulses once every R ticks of `ref_en_i`.
- R6: With `pol_inv_i` at 0, a leading feedback pulse drives `pump_dn_o` and a leading reference pulse drives `pump_up_o`. With `pol_inv_i` at 1 the two outputs swap. The two are never high together.
- R7: While `pump_off_i` is 1, `pump_up_o` and `pump_dn_o` are 0 and `pump_oe_o` is 0 (pump high-impedance). Otherwise `pump_oe_o` is 1.
- R8: Local lock (high = locked) is set once 16 consecutive reference periods each show fewer than 4 cycles of pump activity. A single period with 4 or more cycles clears it.
- R9: `lock_o` = `ext_lock_i` AND selected lock. `lock_sel_i` = 0 selects local lock XOR `rx_lock_inv_i`; `lock_sel_i` = 1 selects `tx_lock_i` XOR `tx_lock_inv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vco_en_i | input | 1 | Oscillator-side tick |
| ref_en_i | input | 1 | Reference tick |
| m_i | input | 11 | Frame length M in prescaler cycles |
| a_i | input | 7 | Swallow count A |
| r_i | input | 15 | Reference division R |
| psc_code_i | input | 3 | Prescaler base select |
| pol_inv_i | input | 1 | Swap pump-up and pump-down |
| pump_off_i | input | 1 | Park pump in high-impedance |
| rx_lock_inv_i | input | 1 | Invert local lock |
| tx_lock_inv_i | input | 1 | Invert companion lock |
| lock_sel_i | input | 1 | 0 local lock, 1 companion lock |
| tx_lock_i | input | 1 | Companion synthesiser lock |
| ext_lock_i | input | 1 | External lock input |
| fdiv_o | output | 1 | Divided feedback pulse |
| rdiv_o | output | 1 | Divided reference pulse |
| mod_ctl_o | output | 1 | Prescaler modulus control (1 = N+1) |
| pump_up_o | output | 1 | Pump-up control |
| pump_dn_o | output | 1 | Pump-down control |
| pump_oe_o | output | 1 | Pump drive enable |
| lock_o | output | 1 | Combined lock flag |
| prog_err_o | output | 1 | Invalid programming flag |

## Verification
The bench uses the default parameters: 11/7/15-bit fields, a quiet tolerance of 4 cycles and a 16-period lock run. The reset setting (code 0, M=4, A=2, R=34) makes the two dividers equal and phase-aligned from reset, so true lock is reachable within a few hundred cycles. Changing R to 35 then gives a steady one-cycle drift per period, which breaks lock and produces pump activity of one known sense. The feedback vectors span all five prescaler bases, including A = N−1, A = 0 and M = 1.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
    localparam int M_W    = 11;
    localparam int A_W    = 7;
    localparam int R_W    = 15;
    localparam int CODE_W = 3;
    localparam int MOD_W  = 8;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [M_W-1:0]    m;
        logic [A_W-1:0]    a;
        logic [R_W-1:0]    r;
    } div_cfg_t;

    // base modulus N of the two-modulus prescaler
    function automatic logic [MOD_W-1:0] base_modulus(input logic [CODE_W-1:0] code);
        if (!code[2]) return MOD_W'(8);
        return MOD_W'(16) << code[1:0];
    endfunction
endpackage

// File: rtl/pll_prescaler.sv
module pll_prescaler #(
    parameter int MW = pll_div_pkg::MOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vco_en_i,
    input  logic [MW-1:0] base_i,
    input  logic          mod_hi_i,
    output logic          wrap_o
);
    logic [MW-1:0] pc_d, pc_q;
    logic [MW-1:0] last_idx;

    always_comb begin
        last_idx = base_i + MW'(mod_hi_i) - MW'(1);
        wrap_o   = vco_en_i && (pc_q >= last_idx);
        pc_d     = pc_q;
        if (wrap_o)        pc_d = '0;
        else if (vco_en_i) pc_d = pc_q + MW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/pll_main_div.sv
module pll_main_div #(
    parameter int MW = pll_div_pkg::M_W,
    parameter int AW = pll_div_pkg::A_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_i,
    input  logic [MW-1:0] m_i,
    input  logic [AW-1:0] a_i,
    output logic          mod_hi_o,
    output logic          fdiv_o
);
    typedef struct packed {
        logic [MW-1:0] cnt;
        logic          pulse;
    } st_t;

    st_t s_d, s_q;
    logic frame_end;

    always_comb begin
        mod_hi_o  = s_q.cnt < {{(MW-AW){1'b0}}, a_i};
        frame_end = s_q.cnt >= (m_i - MW'(1));
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (wrap_i) begin
            if (frame_end) begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + MW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fdiv_o = s_q.pulse;
endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
    parameter int RW = pll_div_pkg::R_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_en_i,
    input  logic [RW-1:0] r_i,
    output logic          rdiv_o
);
    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          pulse;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (ref_en_i) begin
            if (s_q.cnt >= (r_i - RW'(1))) begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdiv_o = s_q.pulse;
endmodule

// File: rtl/pll_pfd_lock.sv
module pll_pfd_lock #(
    parameter int TOL    = 4,
    parameter int LOCK_N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o,
    output logic locked_o
);
    localparam int TW = $clog2(TOL + 1);
    localparam int GW = $clog2(LOCK_N + 1);

    typedef struct packed {
        logic          up;
        logic          dn;
        logic [TW-1:0] w;
        logic [GW-1:0] good;
    } st_t;

    st_t s_d, s_q;
    logic          act, up_n, dn_n;
    logic [TW-1:0] w_eff;

    always_comb begin
        s_d  = s_q;
        act  = s_q.up | s_q.dn;
        up_n = s_q.up | ref_i;
        dn_n = s_q.dn | fb_i;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
        s_d.up = up_n;
        s_d.dn = dn_n;

        w_eff = (act && (s_q.w != TW'(TOL))) ? s_q.w + TW'(1) : s_q.w;
        if (ref_i) begin
            s_d.w = '0;
            if (w_eff >= TW'(TOL))              s_d.good = '0;
            else if (s_q.good != GW'(LOCK_N))   s_d.good = s_q.good + GW'(1);
        end else begin
            s_d.w = w_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign up_o     = s_q.up;
    assign dn_o     = s_q.dn;
    assign locked_o = (s_q.good == GW'(LOCK_N));
endmodule

// File: rtl/pll_if_synth_div.sv
module pll_if_synth_div
    import pll_div_pkg::*;
#(
    parameter int TOL      = 4,
    parameter int LOCK_N   = 16,
    parameter int DEF_CODE = 0,
    parameter int DEF_M    = 4,
    parameter int DEF_A    = 2,
    parameter int DEF_R    = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vco_en_i,
    input  logic              ref_en_i,
    input  logic [M_W-1:0]    m_i,
    input  logic [A_W-1:0]    a_i,
    input  logic [R_W-1:0]    r_i,
    input  logic [CODE_W-1:0] psc_code_i,
    input  logic              pol_inv_i,
    input  logic              pump_off_i,
    input  logic              rx_lock_inv_i,
    input  logic              tx_lock_inv_i,
    input  logic              lock_sel_i,
    input  logic              tx_lock_i,
    input  logic              ext_lock_i,
    output logic              fdiv_o,
    output logic              rdiv_o,
    output logic              mod_ctl_o,
    output logic              pump_up_o,
    output logic              pump_dn_o,
    output logic              pump_oe_o,
    output logic              lock_o,
    output logic              prog_err_o
);
    typedef struct packed {
        div_cfg_t cfg;
        logic     err;
    } st_t;

    localparam div_cfg_t CFG_RST = '{code: CODE_W'(DEF_CODE), m: M_W'(DEF_M),
                                    a: A_W'(DEF_A), r: R_W'(DEF_R)};

    st_t            s_d, s_q;
    logic [MOD_W-1:0] base_in, base_act;
    logic           prog_ok, wrap, up_raw, dn_raw, local_lock, rx_l, tx_l;

    always_comb begin
        base_in = base_modulus(psc_code_i);
        prog_ok = (MOD_W'(a_i) < base_in) && (m_i >= M_W'(a_i)) &&
                  (m_i != '0) && (r_i != '0);
        s_d     = s_q;
        s_d.err = !prog_ok;
        if (prog_ok) begin
            s_d.cfg.code = psc_code_i;
            s_d.cfg.m    = m_i;
            s_d.cfg.a    = a_i;
            s_d.cfg.r    = r_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cfg: CFG_RST, err: 1'b0};
        else        s_q <= s_d;
    end

    assign base_act = base_modulus(s_q.cfg.code);

    pll_prescaler #(.MW(MOD_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .vco_en_i(vco_en_i),
        .base_i(base_act), .mod_hi_i(mod_ctl_o), .wrap_o(wrap)
    );

    pll_main_div #(.MW(M_W), .AW(A_W)) u_mdiv (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap),
        .m_i(s_q.cfg.m), .a_i(s_q.cfg.a), .mod_hi_o(mod_ctl_o), .fdiv_o(fdiv_o)
    );

    pll_ref_div #(.RW(R_W)) u_rdiv (
        .clk(clk), .rst_n(rst_n), .ref_en_i(ref_en_i),
        .r_i(s_q.cfg.r), .rdiv_o(rdiv_o)
    );

    pll_pfd_lock #(.TOL(TOL), .LOCK_N(LOCK_N)) u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_i(rdiv_o), .fb_i(fdiv_o),
        .up_o(up_raw), .dn_o(dn_raw), .locked_o(local_lock)
    );

    always_comb begin
        pump_oe_o  = !pump_off_i;
        pump_up_o  = !pump_off_i && (pol_inv_i ? dn_raw : up_raw);
        pump_dn_o  = !pump_off_i && (pol_inv_i ? up_raw : dn_raw);
        rx_l       = local_lock ^ rx_lock_inv_i;
        tx_l       = tx_lock_i ^ tx_lock_inv_i;
        lock_o     = ext_lock_i && (lock_sel_i ? tx_l : rx_l);
        prog_err_o = s_q.err;
    end
endmodule

// File: rtl/pll_if_synth_div_chk.sv
module pll_if_synth_div_chk (
    input logic clk,
    input logic rst_n,
    input logic pump_off_i,
    input logic ext_lock_i,
    input logic fdiv_o,
    input logic pump_up_o,
    input logic pump_dn_o,
    input logic pump_oe_o,
    input logic lock_o
);
    // R6
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pump_up_o, pump_dn_o}));

    // R7
    pump_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_off_i |-> (!pump_up_o && !pump_dn_o && !pump_oe_o));

    // R1
    fdiv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fdiv_o |=> !fdiv_o);

    // R9
    lock_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> ext_lock_i);

    // R7
    pump_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_off_i |-> pump_oe_o);
endmodule

bind pll_if_synth_div pll_if_synth_div_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pump_off_i(pump_off_i), .ext_lock_i(ext_lock_i),
    .fdiv_o(fdiv_o), .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o),
    .pump_oe_o(pump_oe_o), .lock_o(lock_o)
);

// File: tb/sim_pll_if_synth_div.sv
`timescale 1ns/1ps
module sim_pll_if_synth_div;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vco_en = 1'b1;
    logic ref_tog = 1'b0;
    logic tog_mode = 1'b0;
    wire  ref_en = tog_mode ? ref_tog : 1'b1;
    logic [10:0] m = 11'd4;
    logic [6:0]  a = 7'd2;
    logic [14:0] r = 15'd34;
    logic [2:0]  code = 3'd0;
    logic pol = 1'b0, poff = 1'b0, rxinv = 1'b0, txinv = 1'b0, sel = 1'b0;
    logic txl = 1'b0, extl = 1'b1;
    logic fdiv, rdiv, modc, pup, pdn, poe, lock, perr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) if (tog_mode) ref_tog <= ~ref_tog;

    pll_if_synth_div u0 (
        .clk(clk), .rst_n(rst_n), .vco_en_i(vco_en), .ref_en_i(ref_en),
        .m_i(m), .a_i(a), .r_i(r), .psc_code_i(code), .pol_inv_i(pol),
        .pump_off_i(poff), .rx_lock_inv_i(rxinv), .tx_lock_inv_i(txinv),
        .lock_sel_i(sel), .tx_lock_i(txl), .ext_lock_i(extl),
        .fdiv_o(fdiv), .rdiv_o(rdiv), .mod_ctl_o(modc), .pump_up_o(pup),
        .pump_dn_o(pdn), .pump_oe_o(poe), .lock_o(lock), .prog_err_o(perr)
    );

    // vectors: code, M, A, expected ratio M*N+A, expected N+1 cycles A*(N+1)
    localparam int NV = 6;
    localparam int V_CODE [NV] = '{3, 4, 5, 6, 7, 0};
    localparam int V_M    [NV] = '{5, 15, 2, 2, 1, 7};
    localparam int V_A    [NV] = '{3, 15, 1, 0, 1, 7};
    localparam int V_RAT  [NV] = '{43, 255, 65, 128, 129, 63};
    localparam int V_MC   [NV] = '{27, 255, 33, 0, 129, 63};

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // period of fdiv in cycles and count of N+1 cycles within that frame
    task automatic meas_fb(output int per, output int mc);
        do @(negedge clk); while (!fdiv);
        mc = int'(modc);
        per = 0;
        forever begin
            @(negedge clk);
            per++;
            if (fdiv) break;
            mc += int'(modc);
        end
    endtask

    task automatic meas_ref(output int per);
        do @(negedge clk); while (!rdiv);
        per = 0;
        do begin @(negedge clk); per++; end while (!rdiv);
    endtask

    task automatic pump_count(input int n, output int ups, output int dns);
        ups = 0; dns = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ups += int'(pup);
            dns += int'(pdn);
        end
    endtask

    initial begin
        int p, mc, ups, dns;
        cycles(3);
        // reset state
        chk("R1 reset fdiv", int'(fdiv), 0);
        chk("R8 reset lock", int'(lock), 0);
        chk("R4 reset err", int'(perr), 0);
        chk("R7 reset oe", int'(poe), 1);
        rst_n = 1'b1;

        // R8: aligned dividers (34 vs 34) reach lock
        cycles(700);
        chk("R8 locked", int'(lock), 1);
        pump_count(100, ups, dns);
        chk("R6 idle up", ups, 0);
        chk("R6 idle dn", dns, 0);

        // R9 gating
        extl = 1'b0; #1; chk("R9 ext low", int'(lock), 0);
        extl = 1'b1; rxinv = 1'b1; #1; chk("R9 rx invert", int'(lock), 0);
        rxinv = 1'b0; sel = 1'b1; txl = 1'b1; #1; chk("R9 tx sel", int'(lock), 1);
        txinv = 1'b1; #1; chk("R9 tx invert", int'(lock), 0);
        txl = 1'b0; #1; chk("R9 tx inv low", int'(lock), 1);
        sel = 1'b0; txinv = 1'b0; #1; chk("R9 rx sel", int'(lock), 1);
        @(negedge clk);

        // R5 reference period with tick every cycle
        meas_ref(p); chk("R5 ref 34", p, 34);

        // R8 drift breaks lock; R6 polarity; R7 park
        r = 15'd35;
        cycles(12 * 35);
        chk("R8 unlocked", int'(lock), 0);
        pump_count(200, ups, dns);
        chk("R6 fb lead up", ups, 0);
        chk("R6 fb lead dn", int'(dns > 0), 1);
        pol = 1'b1;
        pump_count(200, ups, dns);
        chk("R6 swap up", int'(ups > 0), 1);
        chk("R6 swap dn", dns, 0);
        poff = 1'b1;
        pump_count(200, ups, dns);
        chk("R7 parked pumps", ups + dns, 0);
        chk("R7 parked oe", int'(poe), 0);
        poff = 1'b0; pol = 1'b0;
        @(negedge clk);
        chk("R7 drive oe", int'(poe), 1);

        // R1 R2 R3 vector walk
        for (int k = 0; k < NV; k++) begin
            code = 3'(V_CODE[k]); m = 11'(V_M[k]); a = 7'(V_A[k]);
            meas_fb(p, mc);
            meas_fb(p, mc);
            chk($sformatf("R1 R2 ratio vec%0d", k), p, V_RAT[k]);
            chk($sformatf("R3 modulus vec%0d", k), mc, V_MC[k]);
        end

        // R4: A == N with last valid code0 M=7 A=7
        a = 7'd8;
        cycles(2);
        chk("R4 a eq n flag", int'(perr), 1);
        meas_fb(p, mc); meas_fb(p, mc);
        chk("R4 a eq n kept", p, 63);
        m = 11'd3; a = 7'd5;
        cycles(2);
        chk("R4 m lt a flag", int'(perr), 1);
        m = 11'd0; a = 7'd0;
        cycles(2);
        chk("R4 m zero flag", int'(perr), 1);
        meas_fb(p, mc); meas_fb(p, mc);
        chk("R4 m zero kept", p, 63);
        m = 11'd4; a = 7'd2;
        cycles(2);
        chk("R4 clear", int'(perr), 0);
        meas_fb(p, mc); meas_fb(p, mc);
        chk("R1 R2 ratio back", p, 34);

        // R5 with sparse reference ticks, then R = 0 rejected
        r = 15'd5; tog_mode = 1'b1;
        meas_ref(p); meas_ref(p);
        chk("R5 ref 5 half rate", p, 10);
        r = 15'd0;
        cycles(2);
        chk("R4 r zero flag", int'(perr), 1);
        meas_ref(p); meas_ref(p);
        chk("R4 r zero kept", p, 10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule